// File: doc/BRIEF.md
# One-Word Four-Phase Relay Stage

This block is a single stage of a FIFO chain that moves one word at a time from a left peer to a right peer. On both sides it uses a return-to-zero request/acknowledge handshake beside a parallel data bus that carries a full word. The left port acts as a receiver. It sees request high, captures the word, raises acknowledge, waits for request to fall, then lowers acknowledge. The right port acts as a sender. It waits for acknowledge low, presents the word, raises request one cycle later, waits for acknowledge high, then lowers request.

Either peer may run on a clock unrelated to the stage's own clock. The two incoming control lines, left request and right acknowledge, each pass through a chain of two flip-flops before any decision uses them. The left data bus has no synchroniser. It is sampled only after the synchronised request is seen high, and by then the peer has held the bus stable for at least two cycles.

The stage holds at most one word. While that word has not been delivered, the left acknowledge stays low, which pushes back on the left peer. Reset is synchronous and active high, and returns both ports and the holding register to idle.

Top module: `hs_relay`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following edge leaves `ack_l` = 0, `req_r` = 0, `data_r` = 0 and the stage empty.
- R2: With the stage empty, once `req_l` has been high for two synchronising edges, the stage captures `data_l` and raises `ack_l` on the same edge. The word later shown on `data_r` when `req_r` rises equals the word that was on `data_l` at that capture.
- R3: `ack_l` stays high as long as the synchronised `req_l` is high. It falls on the edge after the synchronised `req_l` is seen low.
- R4: `ack_l` never rises while the stage holds a word that has not been delivered. At most one word is inside the stage at any time.
- R5: `req_r` rises only if the synchronised `ack_r` was low two edges earlier. A new send therefore waits for the right peer to return acknowledge to zero.
- R6: `data_r` carries the word for at least one cycle before `req_r` rises, and it does not change while `req_r` is high.
- R7: `req_r` stays high until the synchronised `ack_r` is seen high, falls on the next edge, and the word then counts as delivered.
- R8: Each complete left handshake admits exactly one word and each complete right handshake delivers exactly one. Words leave in arrival order, with none lost and none duplicated, under any delays of either peer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous active-high reset |
| req_l | input | 1 | Request from the left peer (asynchronous to clk) |
| ack_l | output | 1 | Acknowledge to the left peer |
| data_l | input | DW | Word from the left peer |
| req_r | output | 1 | Request to the right peer |
| ack_r | input | 1 | Acknowledge from the right peer (asynchronous to clk) |
| data_r | output | DW | Word to the right peer |

## Verification
The hardest case to reach from the ports is a full stage with both peers in awkward positions. The left peer already holds a fresh request while the stage is occupied, and the right peer keeps its acknowledge high long after request has dropped. Only in that case do the backpressure rule and the wait for acknowledge-low before the next send matter.

The stimulus runs three phases. A fast phase uses short random delays on both sides. A second phase has a fast left peer and a right peer that releases acknowledge after 8 to 15 cycles, so every new word arrives while the stage is full. A third phase has a slow left peer, so the stage often sits empty. A cycle-by-cycle occupancy model watches every edge of the handshake lines.

// File: rtl/hs_relay_pkg.sv
package hs_relay_pkg;

    // Left side receiver sequencing
    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_ACK  = 1'b1
    } rx_state_t;

    // Right side sender sequencing
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SETUP = 2'd1,
        TX_WAIT  = 2'd2
    } tx_state_t;

    // Holding register contents
    typedef struct packed {
        logic        full;
        logic [63:0] word;
    } slot_t;

    localparam int unsigned MAX_DW = 64;

    // Receiver may accept only into an empty slot
    function automatic logic rx_accept(rx_state_t s, logic req_s, logic full);
        return (s == RX_IDLE) && req_s && !full;
    endfunction

    // Sender may start only when the right peer has returned to zero
    function automatic logic tx_start(tx_state_t s, logic ack_s, logic full);
        return (s == TX_IDLE) && full && !ack_s;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/hs_rx_fsm.sv
module hs_rx_fsm
    import hs_relay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic full,
    output logic take,
    output logic ack
);
    rx_state_t st, st_nx;

    assign take = rx_accept(st, req_s, full);

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE: if (take)   st_nx = RX_ACK;
            RX_ACK:  if (!req_s) st_nx = RX_IDLE;
            default:             st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= RX_IDLE;
        else     st <= st_nx;
    end

    assign ack = (st == RX_ACK);
endmodule

// File: rtl/hs_tx_fsm.sv
module hs_tx_fsm
    import hs_relay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_s,
    input  logic full,
    output logic done,
    output logic req
);
    tx_state_t st, st_nx;

    assign done = (st == TX_WAIT) && ack_s;

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (tx_start(st, ack_s, full)) st_nx = TX_SETUP;
            TX_SETUP: st_nx = TX_WAIT;
            TX_WAIT:  if (ack_s) st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= TX_IDLE;
        else     st <= st_nx;
    end

    assign req = (st == TX_WAIT);
endmodule

// File: rtl/hs_hold.sv
module hs_hold
    import hs_relay_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] din,
    input  logic          done,
    output logic          full,
    output logic [DW-1:0] dout
);
    localparam int unsigned PAD = MAX_DW - DW;

    slot_t slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (take) begin
            slot.full <= 1'b1;
            slot.word <= {{PAD{1'b0}}, din};
        end else if (done) begin
            slot.full <= 1'b0;
        end
    end

    assign full = slot.full;
    assign dout = slot.word[DW-1:0];
endmodule

// File: rtl/hs_relay.sv
module hs_relay #(
    parameter int unsigned DW          = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_l,
    output logic          ack_l,
    input  logic [DW-1:0] data_l,
    output logic          req_r,
    input  logic          ack_r,
    output logic [DW-1:0] data_r
);
    logic req_s, ack_s;
    logic take, done, full;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst(rst), .d(req_l), .q(req_s)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst(rst), .d(ack_r), .q(ack_s)
    );

    hs_rx_fsm u_rx (
        .clk(clk), .rst(rst), .req_s(req_s), .full(full),
        .take(take), .ack(ack_l)
    );

    hs_tx_fsm u_tx (
        .clk(clk), .rst(rst), .ack_s(ack_s), .full(full),
        .done(done), .req(req_r)
    );

    hs_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst(rst), .take(take), .din(data_l),
        .done(done), .full(full), .dout(data_r)
    );
endmodule

// File: rtl/hs_relay_chk.sv
module hs_relay_chk #(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ack_l,
    input logic          req_r,
    input logic [DW-1:0] data_r,
    input logic          req_s,
    input logic          ack_s,
    input logic          full
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!ack_l && !req_r && data_r == '0 && !full)); // R1

    AST_CAPTURE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_l) |-> full); // R2

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_l && req_s) |=> ack_l); // R3

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (ack_l && !req_s) |=> !ack_l); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_l) |-> $past(!full)); // R4

    AST_REQ_WAITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(req_r) |-> $past(!ack_s, 2)); // R5

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        req_r |-> $stable(data_r)); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_r && !ack_s) |=> req_r); // R7

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_r && ack_s) |=> (!req_r && !full)); // R7
endmodule

bind hs_relay hs_relay_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .ack_l(ack_l), .req_r(req_r), .data_r(data_r),
    .req_s(req_s), .ack_s(ack_s), .full(full)
);

// File: tb/hs_relay_tb.sv
module hs_relay_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_l = 1'b0;
    logic          ack_r = 1'b0;
    logic [DW-1:0] data_l = '0;
    logic          ack_l, req_r;
    logic [DW-1:0] data_r;

    always #2 clk = ~clk;

    hs_relay #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .req_l(req_l), .ack_l(ack_l), .data_l(data_l),
        .req_r(req_r), .ack_r(ack_r), .data_r(data_r)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int total  = 0;
    bit mon_on = 1'b0;

    logic [DW-1:0] acc_q[$];
    logic [DW-1:0] rx_q[$];
    int occ = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int i);
        return DW'(i * 16'h3B1) ^ 16'hA5C3;
    endfunction

    // Reference model evaluated on every clock, away from the active edge
    logic p_ack_l = 1'b0, p_req_r = 1'b0, p_req_l = 1'b0;
    logic [DW-1:0] p_data_r = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (ack_l && !p_ack_l) begin
                chk(occ == 0, "R4 ack_l rose while stage held a word", occ, 0);
                acc_q.push_back(data_l);
                occ++;
            end
            if (!ack_l && p_ack_l)
                chk(!req_l, "R3 ack_l fell while req_l high", req_l, 0);
            if (!ack_l && p_ack_l == 1'b1 && p_req_l)
                chk(1'b0, "R3 ack_l fell too soon after req_l fell", 0, 1);
            if (req_r && !p_req_r) begin
                chk(!ack_r, "R5 req_r rose with ack_r high", ack_r, 0);
                chk(data_r == p_data_r, "R6 data_r not set up before req_r", data_r, p_data_r);
                if (acc_q.size() == 0) begin
                    chk(1'b0, "R2 req_r rose with no accepted word", 0, 1);
                end else begin
                    chk(data_r == acc_q[0], "R2 offered word differs from captured", data_r, acc_q[0]);
                    void'(acc_q.pop_front());
                end
            end
            if (req_r && p_req_r)
                chk(data_r == p_data_r, "R6 data_r changed during req_r", data_r, p_data_r);
            if (!req_r && p_req_r) begin
                chk(ack_r, "R7 req_r fell without ack_r", ack_r, 1);
                occ--;
            end
            chk(occ >= 0 && occ <= 1, "R4 occupancy out of range", occ, 1);
        end
        p_ack_l  = ack_l;
        p_req_r  = req_r;
        p_req_l  = req_l;
        p_data_r = data_r;
    end

    task automatic left_send(input logic [DW-1:0] w, input int pre, input int hold);
        repeat (pre) @(negedge clk);
        #1 data_l = w;
        @(negedge clk);
        #1 req_l = 1'b1;
        while (!ack_l) @(negedge clk);
        repeat (hold) @(negedge clk);
        #1 req_l = 1'b0;
        data_l = DW'($urandom);
        while (ack_l) @(negedge clk);
    endtask

    task automatic right_recv(input int pre, input int rel);
        while (!req_r) @(negedge clk);
        repeat (pre) @(negedge clk);
        rx_q.push_back(data_r);
        #1 ack_r = 1'b1;
        while (req_r) @(negedge clk);
        repeat (rel) @(negedge clk);
        #1 ack_r = 1'b0;
    endtask

    task automatic run_phase(input int n, input int lmax, input int rmin, input int rmax);
        int base;
        base = total;
        fork
            begin
                for (int i = 0; i < n; i++)
                    left_send(word_of(base + i), $urandom_range(lmax, 0), $urandom_range(lmax, 0));
            end
            begin
                for (int i = 0; i < n; i++)
                    right_recv($urandom_range(3, 0), $urandom_range(rmax, rmin));
            end
        join
        total = total + n;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        req_l  = 1'b1;
        data_l = 16'hBEEF;
        repeat (5) @(negedge clk);
        // R1: reset dominates even with a request pending
        chk(ack_l == 1'b0, "R1 ack_l after reset", ack_l, 0);
        chk(req_r == 1'b0, "R1 req_r after reset", req_r, 0);
        chk(data_r == '0,  "R1 data_r after reset", data_r, 0);
        req_l = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(ack_l == 1'b0 && req_r == 1'b0, "R1 idle after release", {ack_l, req_r}, 0);
        mon_on = 1'b1;

        run_phase(30, 3, 0, 3);   // both peers quick
        run_phase(20, 1, 8, 15);  // right peer slow to return to zero
        run_phase(20, 12, 0, 2);  // left peer slow

        repeat (10) @(negedge clk);
        chk(rx_q.size() == total, "R8 delivered word count", rx_q.size(), total);
        for (int i = 0; i < total; i++) begin
            if (i < rx_q.size())
                chk(rx_q[i] == word_of(i), "R8 word order and content", rx_q[i], word_of(i));
        end
        chk(occ == 0, "R8 stage empty at end", occ, 0);
        chk(!ack_l && !req_r, "R8 both ports idle at end", {ack_l, req_r}, 0);
        report();
    end
endmodule